// File: doc/BRIEF.md
# Programmable Pixel Color Matrix Converter

This block converts every incoming pixel of three 8-bit components into three new 8-bit components. Each output channel is a weighted sum of the three inputs plus a constant offset. A register write port loads twelve signed 13-bit values, four per output row: three multipliers and one offset. Typical uses are RGB-to-YCbCr conversion, the reverse transform, or a gain and offset correction.

A global 2-bit format field sets where the binary point sits in all twelve values at once. Unity is 4096, 2048 or 1024, which gives coefficient ranges of about ±1.0, ±2.0 or ±4.0. Offsets use the same format, so an offset equal to unity adds the full 256-code pixel range. A control bit chooses between the matrix result and the unchanged input.

The datapath has three registered stages: multiply, sum, and round/clamp. A valid flag travels through the pipeline with the pixel. Format and enable are sampled together with each pixel, so a configuration change never splits a pixel across two settings. After reset the block passes pixels through unchanged, and it holds a standard RGB-to-YCbCr coefficient set in ±2.0 format.

Top module: `color_matrix_conv`

## Requirements
- R1: While rst_n is low and after it is released, out_valid is 0 and out_pix is all zeros until the first pixel leaves the pipeline. The reset state has enable 0 and format 01.
- R2: A pixel accepted while enable is 0 leaves with out_pix equal to its in_pix, bit for bit.
- R3: Each cycle with in_valid high produces exactly one out_valid cycle, 3 clock edges after the edge that accepted it. Pixels leave in arrival order, and out_valid is never high otherwise.
- R4: With enable 1, output channel k (out_pix[8k+7:8k]) is the clamp of floor((Ck0·x0 + Ck1·x1 + Ck2·x2 + Ck3·256 + 2^(F-1)) / 2^F). Here xj is in_pix[8j+7:8j], taken as unsigned. Ckn is the coefficient at address 4k+n. In format 01, F is 11.
- R5: In format 00, F is 12, so 4096 represents 1.0.
- R6: In format 10, F is 10, so 1024 represents 1.0.
- R7: Format 11 gives the same results as format 01.
- R8: Results below 0 give 0, and results above 255 give 255.
- R9: The offset at address 4k+3 follows the active format. It is scaled by 256/2^F, so it adds 64, 128 or 256 codes when it is 1024 in formats 00, 01 or 10.
- R10: A write with cfg_we high to address 0..11 stores cfg_wdata as a 13-bit two's-complement coefficient, used for pixels accepted after that edge. Address 12 stores format from cfg_wdata[1:0] and enable from cfg_wdata[2]. Writes to addresses 13..15 change nothing.
- R11: After reset the coefficients by address 0..11 are 526, 1032, 201, 128, -304, -596, 899, 1024, 899, -753, -146, 1024.
- R12: out_pix holds its value in every cycle in which no pixel leaves the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 13 | Configuration write data |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 24 | Input pixel, component j in bits 8j+7:8j |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 24 | Output pixel, channel k in bits 8k+7:8k |

## Verification
On every cycle, embedded properties check several things: the three-edge valid timing, bit-exact pass-through when the matrix is disabled, quiet outputs during and just after reset, output hold between valid pixels, and that register writes reach the addressed coefficient and leave the bank alone for unmapped addresses. Other behaviour needs a reference computation, so only the bench scenarios can show it. This covers the arithmetic itself, rounding at each format's binary point, saturation at both ends, offset scaling, the format 11 alias and the reset coefficient set. For these the bench drives directed pixels and random configuration and pixel streams, and compares against its own model.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    localparam int NUM_CH   = 3;
    localparam int TERMS    = 4;
    localparam int NUM_COEF = NUM_CH * TERMS;

    typedef enum logic [1:0] {
        FXP_ONE  = 2'b00,
        FXP_TWO  = 2'b01,
        FXP_FOUR = 2'b10,
        FXP_ALT  = 2'b11
    } fxp_mode_e;

    localparam logic [1:0] MODE_RST = FXP_TWO;

    // Number of fraction bits in a coefficient for the given format.
    function automatic int frac_bits(input logic [1:0] mode, input int coef_w);
        case (fxp_mode_e'(mode))
            FXP_ONE:  return coef_w - 1;
            FXP_FOUR: return coef_w - 3;
            default:  return coef_w - 2;
        endcase
    endfunction

    // Reset coefficient set: RGB to limited-range YCbCr, unity = 2048.
    function automatic int rst_coef(input int idx);
        case (idx)
            0:  return 526;
            1:  return 1032;
            2:  return 201;
            3:  return 128;
            4:  return -304;
            5:  return -596;
            6:  return 899;
            7:  return 1024;
            8:  return 899;
            9:  return -753;
            10: return -146;
            11: return 1024;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/cmc_coef_bank.sv
module cmc_coef_bank
    import cmc_pkg::*;
#(
    parameter int COEF_W = 13,
    parameter int ADDR_W = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we_i,
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [COEF_W-1:0]                  wdata_i,
    output logic [NUM_COEF-1:0][COEF_W-1:0]    coef_o,
    output logic [1:0]                         mode_o,
    output logic                               en_o
);

    localparam int CTRL_ADDR = NUM_COEF;

    typedef struct packed {
        logic [NUM_COEF-1:0][COEF_W-1:0] coef;
        logic [1:0]                      mode;
        logic                            en;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic bank_t bank_reset();
        bank_t r;
        for (int k = 0; k < NUM_COEF; k++) begin
            r.coef[k] = COEF_W'(rst_coef(k));
        end
        r.mode = MODE_RST;
        r.en   = 1'b0;
        return r;
    endfunction

    always_comb begin
        bank_d = bank_q;
        if (we_i) begin
            if (int'(addr_i) < NUM_COEF) begin
                bank_d.coef[addr_i] = wdata_i;
            end else if (int'(addr_i) == CTRL_ADDR) begin
                bank_d.mode = wdata_i[1:0];
                bank_d.en   = wdata_i[2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= bank_reset();
        end else begin
            bank_q <= bank_d;
        end
    end

    assign coef_o = bank_q.coef;
    assign mode_o = bank_q.mode;
    assign en_o   = bank_q.en;

    // R10
    ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && int'(addr_i) > CTRL_ADDR) |=> ($stable(coef_o) && $stable(mode_o) && $stable(en_o)));

    // R10
    coef_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && int'(addr_i) < NUM_COEF) |=> (coef_o[$past(addr_i)] == $past(wdata_i)));

endmodule

// File: rtl/cmc_row.sv
module cmc_row
    import cmc_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 13
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            s0_valid_i,
    input  logic                            s1_valid_i,
    input  logic                            s2_valid_i,
    input  logic [NUM_CH-1:0][PIX_W-1:0]    pix_i,
    input  logic [PIX_W-1:0]                byp_pix_i,
    input  logic [TERMS-1:0][COEF_W-1:0]    coef_i,
    input  logic [1:0]                      mode_i,
    input  logic                            en_i,
    output logic [PIX_W-1:0]                pix_o
);

    localparam int PROD_W  = COEF_W + PIX_W + 1;
    localparam int SUM_W   = PROD_W + 2;
    localparam int ACC_W   = SUM_W + 2;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef struct packed {
        logic signed [PROD_W-1:0] p0;
        logic signed [PROD_W-1:0] p1;
        logic signed [PROD_W-1:0] p2;
        logic signed [COEF_W-1:0] off1;
        logic [1:0]               mode1;
        logic                     byp1;
        logic [PIX_W-1:0]         bp1;
        logic signed [SUM_W-1:0]  sum2;
        logic signed [COEF_W-1:0] off2;
        logic [1:0]               mode2;
        logic                     byp2;
        logic [PIX_W-1:0]         bp2;
        logic [PIX_W-1:0]         res;
    } row_t;

    row_t row_d, row_q;

    function automatic logic signed [PROD_W-1:0] mul(input logic signed [COEF_W-1:0] c,
                                                     input logic [PIX_W-1:0] p);
        logic signed [PIX_W:0] ps;
        ps = $signed({1'b0, p});
        return c * ps;
    endfunction

    function automatic logic [PIX_W-1:0] round_clamp(input logic signed [SUM_W-1:0] s,
                                                     input logic signed [COEF_W-1:0] o,
                                                     input logic [1:0] m);
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] q;
        int                      fb;
        fb  = frac_bits(m, COEF_W);
        acc = ACC_W'(s) + (ACC_W'(o) <<< PIX_W) + (ACC_W'(1) <<< (fb - 1));
        q   = acc >>> fb;
        if (q < 0) begin
            return '0;
        end else if (q > PIX_MAX) begin
            return PIX_W'(PIX_MAX);
        end
        return q[PIX_W-1:0];
    endfunction

    always_comb begin
        row_d = row_q;
        // stage 1: products, offset and per-pixel configuration
        if (s0_valid_i) begin
            row_d.p0    = mul(coef_i[0], pix_i[0]);
            row_d.p1    = mul(coef_i[1], pix_i[1]);
            row_d.p2    = mul(coef_i[2], pix_i[2]);
            row_d.off1  = coef_i[3];
            row_d.mode1 = mode_i;
            row_d.byp1  = !en_i;
            row_d.bp1   = byp_pix_i;
        end
        // stage 2: sum of products
        if (s1_valid_i) begin
            row_d.sum2  = SUM_W'(row_q.p0) + SUM_W'(row_q.p1) + SUM_W'(row_q.p2);
            row_d.off2  = row_q.off1;
            row_d.mode2 = row_q.mode1;
            row_d.byp2  = row_q.byp1;
            row_d.bp2   = row_q.bp1;
        end
        // stage 3: offset, rounding, saturation or pass-through
        if (s2_valid_i) begin
            row_d.res = row_q.byp2 ? row_q.bp2
                                   : round_clamp(row_q.sum2, row_q.off2, row_q.mode2);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            row_q <= row_d;
        end
    end

    assign pix_o = row_q.res;

    // R12
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s2_valid_i |=> $stable(pix_o));

endmodule

// File: rtl/color_matrix_conv.sv
module color_matrix_conv
    import cmc_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 13,
    parameter int ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [COEF_W-1:0]           cfg_wdata,
    input  logic                        in_valid,
    input  logic [NUM_CH-1:0][PIX_W-1:0] in_pix,
    output logic                        out_valid,
    output logic [NUM_CH-1:0][PIX_W-1:0] out_pix
);

    typedef struct packed {
        logic v1;
        logic v2;
        logic v3;
    } vpipe_t;

    vpipe_t vp_d, vp_q;

    logic [NUM_COEF-1:0][COEF_W-1:0] coef_all;
    logic [1:0]                      fx_mode;
    logic                            mat_en;

    cmc_coef_bank #(
        .COEF_W (COEF_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .coef_o  (coef_all),
        .mode_o  (fx_mode),
        .en_o    (mat_en)
    );

    always_comb begin
        vp_d    = vp_q;
        vp_d.v1 = in_valid;
        vp_d.v2 = vp_q.v1;
        vp_d.v3 = vp_q.v2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vp_q <= '0;
        end else begin
            vp_q <= vp_d;
        end
    end

    assign out_valid = vp_q.v3;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_row
        cmc_row #(
            .PIX_W  (PIX_W),
            .COEF_W (COEF_W)
        ) u_row (
            .clk        (clk),
            .rst_n      (rst_n),
            .s0_valid_i (in_valid),
            .s1_valid_i (vp_q.v1),
            .s2_valid_i (vp_q.v2),
            .pix_i      (in_pix),
            .byp_pix_i  (in_pix[g]),
            .coef_i     (coef_all[g*TERMS +: TERMS]),
            .mode_i     (fx_mode),
            .en_i       (mat_en),
            .pix_o      (out_pix[g])
        );
    end

    // Edges since reset release, saturating at 3; lets the checks below use $past safely.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R3
    valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && out_valid && $past(!mat_en, 3)) |-> (out_pix == $past(in_pix, 3)));

endmodule

// File: tb/color_matrix_conv_bench.sv
module color_matrix_conv_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [12:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [2:0][7:0] in_pix = '0;
    logic        out_valid;
    logic [2:0][7:0] out_pix;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // bench model of the configuration
    int cm[12];
    int mm;
    int me;

    logic [23:0] eq[$];
    int          cq[$];
    string       tq[$];

    color_matrix_conv u_color_matrix_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    function automatic int calc(input int row, input int p0, input int p1, input int p2, input int m);
        int acc;
        int fb;
        int r;
        acc = cm[row*4]*p0 + cm[row*4+1]*p1 + cm[row*4+2]*p2 + cm[row*4+3]*256;
        fb  = (m == 0) ? 12 : (m == 2) ? 10 : 11;
        r   = (acc + (1 << (fb - 1))) >>> fb;
        if (r < 0)   r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic wr(input int a, input int v);
        @(negedge clk);
        in_valid  = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = 4'(a);
        cfg_wdata = 13'(v);
        if (a < 12) cm[a] = v;
        else if (a == 12) begin
            mm = v & 3;
            me = (v >> 2) & 1;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input int p0, input int p1, input int p2, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_pix   = {8'(p2), 8'(p1), 8'(p0)};
        if (me == 0) eq.push_back({8'(p2), 8'(p1), 8'(p0)});
        else eq.push_back({8'(calc(2, p0, p1, p2, mm)), 8'(calc(1, p0, p1, p2, mm)),
                           8'(calc(0, p0, p1, p2, mm))});
        cq.push_back(cyc);
        tq.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic drain();
        idle(1);
        while (eq.size() != 0 && !done) idle(1);
        idle(2);
    endtask

    // output monitor: ordering, latency (R3) and values (tag of the stimulus)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (eq.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R3 actual=out_valid expected=no pixel pending at cycle %0d", cyc);
            end else begin
                check("R3", 24'(cyc), 24'(cq[0] + 3));
                check(tq[0], out_pix, eq[0]);
                void'(eq.pop_front());
                void'(cq.pop_front());
                void'(tq.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R3 watchdog actual=%0d cycles expected=completion", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        logic [23:0] held;
        void'($urandom(32'd5150));
        for (int k = 0; k < 12; k++) cm[k] = 0;
        // R11 reset coefficient values
        cm[0] = 526;  cm[1] = 1032; cm[2]  = 201;  cm[3]  = 128;
        cm[4] = -304; cm[5] = -596; cm[6]  = 899;  cm[7]  = 1024;
        cm[8] = 899;  cm[9] = -753; cm[10] = -146; cm[11] = 1024;
        mm = 1;
        me = 0;

        // R1: reset state
        idle(3);
        check("R1", {23'd0, out_valid}, 24'd0);
        check("R1", out_pix, 24'd0);
        rst_n = 1'b1;
        idle(2);
        check("R1", {23'd0, out_valid}, 24'd0);
        check("R1", out_pix, 24'd0);

        // R2: pass-through while disabled (reset default)
        send(10, 200, 33, "R2");
        send(255, 0, 128, "R2");
        send(1, 254, 77, "R2");
        drain();

        // R11: reset coefficients in format 01
        wr(12, 4 | 1);
        send(255, 255, 255, "R11");
        send(0, 0, 0, "R11");
        send(255, 0, 0, "R11");
        send(0, 255, 0, "R11");
        drain();

        // R4: random pixels, format 01
        for (int i = 0; i < 20; i++)
            send($urandom_range(255), $urandom_range(255), $urandom_range(255), "R4");
        drain();

        // R9: offsets only, all three formats
        for (int k = 0; k < 12; k++) wr(k, 0);
        wr(3, 1024); wr(7, -512); wr(11, 300);
        for (int m = 0; m < 3; m++) begin
            wr(12, 4 | m);
            send(17, 99, 200, "R9");
        end
        drain();

        // R5 / R6: random coefficients in formats 00 and 10
        for (int m = 0; m <= 2; m += 2) begin
            wr(12, 4 | m);
            for (int i = 0; i < 6; i++) begin
                for (int k = 0; k < 12; k++) wr(k, int'($urandom_range(2048)) - 1024);
                for (int j = 0; j < 5; j++)
                    send($urandom_range(255), $urandom_range(255), $urandom_range(255),
                         (m == 0) ? "R5" : "R6");
            end
        end
        drain();

        // R7: format 11 equals format 01
        wr(12, 4 | 3);
        for (int i = 0; i < 8; i++)
            send($urandom_range(255), $urandom_range(255), $urandom_range(255), "R7");
        wr(12, 4 | 1);
        send(200, 100, 50, "R7");
        wr(12, 4 | 3);
        send(200, 100, 50, "R7");
        drain();

        // R8: saturation high and low
        wr(12, 4 | 1);
        for (int k = 0; k < 4; k++) wr(k, 4095);
        for (int k = 4; k < 8; k++) wr(k, -4096);
        wr(8, 700); wr(9, -700); wr(10, 0); wr(11, 0);
        send(255, 255, 255, "R8");
        send(0, 255, 0, "R8");
        send(255, 0, 0, "R8");
        drain();

        // R10: unmapped addresses leave the configuration unchanged
        wr(13, 4095); wr(14, -1); wr(15, 5);
        send(90, 40, 180, "R10");
        send(0, 0, 255, "R10");
        wr(9, 1500);
        send(90, 40, 180, "R10");
        drain();

        // R4: mixed random traffic with configuration changes in flight
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = $urandom_range(9);
            if (sel == 0) wr($urandom_range(11), int'($urandom_range(8191)) - 4096);
            else if (sel == 1) wr(12, $urandom_range(7));
            else if (sel == 2) idle($urandom_range(3));
            else send($urandom_range(255), $urandom_range(255), $urandom_range(255), "R4");
        end
        drain();
        check("R3", 24'(eq.size()), 24'd0);

        // R12: outputs hold with no traffic
        held = out_pix;
        for (int i = 0; i < 10; i++) begin
            idle(1);
            check("R12", out_pix, held);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule